// File: doc/BRIEF.md
# Configurable-Width IQ Sample Packer

This block sits in a receive datapath after the channel filters. It accepts one complex sample per handshake: an in-phase and a quadrature component, 16 bits each. It narrows each component to 16, 8, 4, 2 or 1 bits by keeping its top bits. It then packs the narrowed pairs into 32-bit words. The first pair of a word takes the least significant lanes. Within each pair, I sits directly below Q.

A word is released only when all of its lanes hold data. A flush request releases a partly filled word, with the empty lanes set to zero. A reverse control mirrors the lane order inside each word, so that the earliest sample lands at the top. This suits consumers that record words to storage unchanged.

The width and reverse controls are taken when a word starts. They then stay fixed until that word leaves the block. A single output register decouples the packer from a stalling consumer, and any backpressure reaches the sample input at once.

Top module: `iq_lane_packer`

## Requirements
- R1: With `width_sel` = 0 (16-bit lanes), each word holds one pair: I in bits 15:0 and Q in bits 31:16.
- R2: With `width_sel` = 1 (8-bit lanes), each word holds two pairs. Pair k places I at bits 16k+7:16k and Q at bits 16k+15:16k+8, so the word reads I0, Q0, I1, Q1 from the LSB upward.
- R3: Codes 2, 3 and 4 select 4-, 2- and 1-bit lanes, with 4, 8 and 16 pairs per word. For lane width N, pair k places I at bits 2kN+N-1:2kN and Q in the N bits directly above.
- R4: A narrowed component is the top N bits of the 16-bit input, with no rounding.
- R5: `width_sel` codes 5, 6 and 7 behave exactly like code 0.
- R6: When reverse is in effect, a word of L lanes moves lane j to lane L-1-j. The first I then occupies the most significant lane and the first Q the lane below it.
- R7: With no flush, `out_valid` rises only in the cycle after the edge that accepts the last pair of a word. It never rises after fewer pairs than the word holds.
- R8: `flush`, sampled while `in_ready` is high with at least one pair pending, releases the partial word with unused lanes zero. Zero lanes are filled before reversal is applied. A pair accepted in the same cycle is included in that word. A flush with nothing pending produces no word.
- R9: `width_sel` and `reverse_lanes` are latched with the first pair of a word. Changes made while a word is open take effect from the next word.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_word` holds steady. Under any backpressure, every accepted pair appears exactly once.
- R11: A synchronous reset empties the partial word and the output register, leaving `out_valid` low and `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| width_sel | input | 3 | Lane width code: 0=16, 1=8, 2=4, 3=2, 4=1 bits; 5-7 as 0 |
| reverse_lanes | input | 1 | Mirror lane order inside each word |
| flush | input | 1 | Release the pending partial word |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Sample pair can be taken |
| in_i | input | 16 | In-phase component |
| in_q | input | 16 | Quadrature component |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Packed word |

## Verification
The properties assume that `rst` is high at the first clock edge. They also assume that `flush` and the two handshake inputs are free of X once reset has ended.

The stimulus drives every input shortly after the falling edge, so all inputs are settled before the rising edge. The random phase freely changes `width_sel` (including the unused codes), `reverse_lanes`, `flush`, `in_valid` and `out_ready` from cycle to cycle. All of these are legal, so the assumptions hold for every cycle the bench produces.

// File: rtl/iq_pack_pkg.sv
package iq_pack_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 5;

  typedef logic [MODE_W-1:0] mode_t;

  // Unused codes fall back to full-width lanes.
  function automatic mode_t mode_norm(input logic [MODE_W-1:0] raw);
    return (raw < MODE_W'(NUM_MODES)) ? raw : '0;
  endfunction

  function automatic int lane_bits(input int comp_w, input int m);
    return comp_w >> m;
  endfunction

  function automatic int pairs_per_word(input int word_w, input int comp_w, input int m);
    return word_w / (2 * lane_bits(comp_w, m));
  endfunction

  function automatic int lanes_per_word(input int word_w, input int comp_w, input int m);
    return word_w / lane_bits(comp_w, m);
  endfunction
endpackage

// File: rtl/iq_pack_cfg.sv
module iq_pack_cfg
  import iq_pack_pkg::*;
#(
  parameter int COMP_W = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] width_req,
  input  logic              rev_req,
  input  logic              word_open,
  input  logic              load,
  output mode_t             eff_mode,
  output logic              eff_rev,
  output logic [CNT_W-1:0]  eff_pairs
);
  mode_t            live_mode;
  mode_t            held_mode;
  logic             held_rev;
  logic [CNT_W-1:0] pair_tab [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_tab
    assign pair_tab[m] = CNT_W'(pairs_per_word(WORD_W, COMP_W, m));
  end

  assign live_mode = mode_norm(width_req);
  assign eff_mode  = word_open ? held_mode : live_mode;
  assign eff_rev   = word_open ? held_rev  : rev_req;
  assign eff_pairs = pair_tab[eff_mode];

  always_ff @(posedge clk) begin
    if (rst) begin
      held_mode <= '0;
      held_rev  <= 1'b0;
    end else if (load) begin
      held_mode <= live_mode;
      held_rev  <= rev_req;
    end
  end
endmodule

// File: rtl/iq_pack_insert.sv
module iq_pack_insert
  import iq_pack_pkg::*;
#(
  parameter int COMP_W = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [WORD_W-1:0] part_in,
  input  logic [CNT_W-1:0]  slot,
  input  logic [COMP_W-1:0] i_in,
  input  logic [COMP_W-1:0] q_in,
  input  mode_t             mode,
  output logic [WORD_W-1:0] placed
);
  logic [WORD_W-1:0] cand [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int N  = COMP_W >> m;
    localparam int PW = 2 * N;
    logic [PW-1:0] pair_bits;
    // Truncation: only the top N bits of each component survive.
    assign pair_bits = {q_in[COMP_W-1 -: N], i_in[COMP_W-1 -: N]};
    assign cand[m]   = part_in | (WORD_W'(pair_bits) << (slot * PW));
  end

  assign placed = cand[mode];
endmodule

// File: rtl/iq_pack_reverse.sv
module iq_pack_reverse
  import iq_pack_pkg::*;
#(
  parameter int COMP_W = 16,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_in,
  input  mode_t             mode,
  input  logic              rev,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] flip [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int N = COMP_W >> m;
    localparam int L = WORD_W / N;
    logic [WORD_W-1:0] fl;
    always_comb begin
      for (int k = 0; k < L; k++) fl[k*N +: N] = word_in[(L-1-k)*N +: N];
    end
    assign flip[m] = fl;
  end

  assign word_out = rev ? flip[mode] : word_in;
endmodule

// File: rtl/iq_pack_out.sv
module iq_pack_out #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              take,
  output logic              valid,
  output logic [WORD_W-1:0] word,
  output logic              free
);
  assign free = !valid || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      word  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      word  <= load_word;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_lane_packer.sv
module iq_lane_packer
  import iq_pack_pkg::*;
#(
  parameter int COMP_W = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        width_sel,
  input  logic              reverse_lanes,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COMP_W-1:0] in_i,
  input  logic [COMP_W-1:0] in_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  localparam int MAX_PAIRS = WORD_W / (2 * (COMP_W >> (NUM_MODES - 1)));
  localparam int CNT_W     = $clog2(MAX_PAIRS + 1);

  logic [CNT_W-1:0]  fill_cnt;
  logic [CNT_W-1:0]  fill_next;
  logic [CNT_W-1:0]  eff_pairs;
  logic [WORD_W-1:0] part_q;
  logic [WORD_W-1:0] placed;
  logic [WORD_W-1:0] part_next;
  logic [WORD_W-1:0] ordered;
  mode_t             eff_mode;
  logic              eff_rev;

  // Named internal events, observed by the bound checker.
  logic word_open;
  logic slot_free;
  logic accept_evt;
  logic full_evt;
  logic flush_evt;
  logic emit_evt;

  assign word_open  = (fill_cnt != '0);
  assign in_ready   = slot_free;
  assign accept_evt = in_valid && slot_free;
  assign fill_next  = fill_cnt + CNT_W'(accept_evt);
  assign full_evt   = accept_evt && (fill_next == eff_pairs);
  assign part_next  = accept_evt ? placed : part_q;
  assign flush_evt  = flush && slot_free && !full_evt && (fill_next != '0);
  assign emit_evt   = full_evt || flush_evt;

  iq_pack_cfg #(.COMP_W(COMP_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .width_req (width_sel),
    .rev_req   (reverse_lanes),
    .word_open (word_open),
    .load      (accept_evt && !word_open),
    .eff_mode  (eff_mode),
    .eff_rev   (eff_rev),
    .eff_pairs (eff_pairs)
  );

  iq_pack_insert #(.COMP_W(COMP_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_ins (
    .part_in (part_q),
    .slot    (fill_cnt),
    .i_in    (in_i),
    .q_in    (in_q),
    .mode    (eff_mode),
    .placed  (placed)
  );

  iq_pack_reverse #(.COMP_W(COMP_W), .WORD_W(WORD_W)) u_rev (
    .word_in  (part_next),
    .mode     (eff_mode),
    .rev      (eff_rev),
    .word_out (ordered)
  );

  iq_pack_out #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (emit_evt),
    .load_word (ordered),
    .take      (out_ready),
    .valid     (out_valid),
    .word      (out_word),
    .free      (slot_free)
  );

  always_ff @(posedge clk) begin
    if (rst || emit_evt) begin
      fill_cnt <= '0;
      part_q   <= '0;
    end else begin
      fill_cnt <= fill_next;
      part_q   <= part_next;
    end
  end
endmodule

// File: rtl/iq_lane_packer_chk.sv
module iq_lane_packer_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic [CNT_W-1:0]  fill_cnt,
  input logic [CNT_W-1:0]  eff_pairs,
  input logic              emit_evt
);
  assert_hold_word_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_stall_input_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
    fill_cnt < eff_pairs);

  assert_emit_result_R7: assert property (@(posedge clk) disable iff (rst)
    emit_evt |=> (out_valid && fill_cnt == '0));

  assert_idle_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (flush && fill_cnt == '0 && !in_valid && !out_valid) |=> !out_valid);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (fill_cnt == '0 && !out_valid));
endmodule

bind iq_lane_packer iq_lane_packer_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .fill_cnt  (fill_cnt),
  .eff_pairs (eff_pairs),
  .emit_evt  (emit_evt)
);

// File: tb/iq_lane_packer_test.sv
module iq_lane_packer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  width_sel = '0;
  logic        reverse_lanes = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0;
  logic [15:0] in_q = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;

  always #4 clk = ~clk;

  iq_lane_packer uut (
    .clk(clk), .rst(rst), .width_sel(width_sel), .reverse_lanes(reverse_lanes),
    .flush(flush), .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  int n_chk = 0;
  int n_bad = 0;
  int seen_n = 0;
  logic [31:0] last_seen = '0;
  bit obs_ready;

  // Bench model of the packing rule.
  int          mcnt = 0;
  int          mmode = 0;
  bit          mrev = 0;
  logic [15:0] mi [16];
  logic [15:0] mq [16];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int norm(logic [2:0] ws);
    return (ws < 3'd5) ? int'(ws) : 0;
  endfunction

  function automatic logic [31:0] build_word(int mode, bit rev, int n_pairs);
    int nb = 16 >> mode;
    int lanes = 32 / nb;
    logic [31:0] w = '0;
    for (int p = 0; p < n_pairs; p++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] v = c ? mq[p] : mi[p];
        int lane = 2 * p + c;
        int pos = rev ? lanes - 1 - lane : lane;
        for (int b = 0; b < nb; b++) w[pos * nb + b] = v[16 - nb + b];
      end
    end
    return w;
  endfunction

  function automatic string tag_for(int mode, bit rev, bit part);
    string t = (mode == 0) ? "R1" : (mode == 1) ? "R2" : "R3";
    t = {t, "/R4"};
    if (rev) t = {t, "/R6"};
    if (part) t = {t, "/R8"};
    return t;
  endfunction

  task automatic push_word(bit part);
    exp_q.push_back(build_word(mmode, mrev, mcnt));
    tag_q.push_back(tag_for(mmode, mrev, part));
    mcnt = 0;
  endtask

  task automatic step(bit iv, logic [15:0] ii, logic [15:0] qq, bit fl,
                      logic [2:0] ws, bit rv, bit ordy);
    @(negedge clk);
    in_valid = iv; in_i = ii; in_q = qq; flush = fl;
    width_sel = ws; reverse_lanes = rv; out_ready = ordy;
    #1;
    obs_ready = in_ready;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7/R10 unexpected word", out_word, 32'h0);
      end else begin
        check(out_word === exp_q[0], tag_q[0], out_word, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      last_seen = out_word;
      seen_n++;
    end
    if (in_valid && in_ready) begin
      if (mcnt == 0) begin
        mmode = norm(ws);
        mrev = rv;
      end
      mi[mcnt] = ii;
      mq[mcnt] = qq;
      mcnt++;
      if (mcnt == (1 << mmode)) push_word(1'b0);
    end
    if (fl && in_ready && mcnt > 0) push_word(1'b1);
  endtask

  task automatic send(logic [15:0] ii, logic [15:0] qq, logic [2:0] ws, bit rv);
    step(1'b1, ii, qq, 1'b0, ws, rv, 1'b1);
  endtask

  task automatic idle(logic [2:0] ws, bit rv);
    step(1'b0, 16'h0, 16'h0, 1'b0, ws, rv, 1'b1);
  endtask

  task automatic expect_last(string tag, int mark, logic [31:0] expv);
    check(seen_n > mark && last_seen === expv, tag, last_seen, expv);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int mark;
    logic [31:0] held;
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle(3'd0, 1'b0);
    // R11: cleared after reset
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 reset state",
          {30'b0, out_valid, in_ready}, 32'h1);

    // R1: 16-bit layout
    mark = seen_n;
    send(16'h1234, 16'hABCD, 3'd0, 1'b0); idle(3'd0, 1'b0);
    expect_last("R1 16-bit layout", mark, 32'hABCD1234);

    // R2 and R7: 8-bit, no word after first pair
    mark = seen_n;
    send(16'h1234, 16'hABCD, 3'd1, 1'b0); idle(3'd1, 1'b0);
    check(out_valid == 1'b0, "R7 no early word", {31'b0, out_valid}, 32'h0);
    send(16'h5678, 16'hEF01, 3'd1, 1'b0); idle(3'd1, 1'b0);
    expect_last("R2 8-bit layout", mark, 32'hEF56AB12);

    // R6: reversed 8-bit
    mark = seen_n;
    send(16'h1234, 16'hABCD, 3'd1, 1'b1); send(16'h5678, 16'hEF01, 3'd1, 1'b1);
    idle(3'd1, 1'b1);
    expect_last("R6 reversed 8-bit", mark, 32'h12AB56EF);

    // R8: flush of a partial 4-bit word
    mark = seen_n;
    send(16'hF000, 16'h3000, 3'd2, 1'b0);
    step(1'b0, 16'h0, 16'h0, 1'b1, 3'd2, 1'b0, 1'b1); idle(3'd2, 1'b0);
    expect_last("R8 partial flush", mark, 32'h0000003F);
    mark = seen_n;
    send(16'hF000, 16'h3000, 3'd2, 1'b1);
    step(1'b0, 16'h0, 16'h0, 1'b1, 3'd2, 1'b1, 1'b1); idle(3'd2, 1'b1);
    expect_last("R8/R6 reversed partial flush", mark, 32'hF3000000);
    mark = seen_n;
    step(1'b1, 16'hF000, 16'h3000, 1'b1, 3'd2, 1'b0, 1'b1); idle(3'd2, 1'b0);
    expect_last("R8 flush with same-cycle pair", mark, 32'h0000003F);

    // R8: flush with nothing pending
    mark = seen_n;
    step(1'b0, 16'h0, 16'h0, 1'b1, 3'd2, 1'b0, 1'b1); idle(3'd2, 1'b0);
    check(out_valid == 1'b0 && seen_n == mark, "R8 empty flush",
          {31'b0, out_valid}, 32'h0);

    // R5: unused code acts as 16-bit
    mark = seen_n;
    send(16'h1234, 16'hABCD, 3'd7, 1'b0); idle(3'd7, 1'b0);
    expect_last("R5 code 7", mark, 32'hABCD1234);

    // R9: mid-word change deferred
    mark = seen_n;
    send(16'h1234, 16'hABCD, 3'd1, 1'b0); send(16'h5678, 16'hEF01, 3'd0, 1'b1);
    idle(3'd0, 1'b1);
    expect_last("R9 settings held in word", mark, 32'hEF56AB12);
    mark = seen_n;
    send(16'h1111, 16'h2222, 3'd0, 1'b1); idle(3'd0, 1'b1);
    expect_last("R9 new settings next word", mark, 32'h11112222);

    // R4: 1-bit truncation
    mark = seen_n;
    for (int p = 0; p < 16; p++) send((p % 2 == 0) ? 16'h8000 : 16'h7FFF, 16'hFFFF, 3'd4, 1'b0);
    idle(3'd4, 1'b0);
    expect_last("R4 1-bit truncation", mark, 32'hBBBBBBBB);

    // R10: backpressure
    step(1'b1, 16'hAAAA, 16'hBBBB, 1'b0, 3'd0, 1'b0, 1'b0);
    step(1'b1, 16'hCCCC, 16'hDDDD, 1'b0, 3'd0, 1'b0, 1'b0);
    check(obs_ready == 1'b0, "R10 in_ready low while held", {31'b0, obs_ready}, 32'h0);
    held = out_word;
    step(1'b1, 16'hCCCC, 16'hDDDD, 1'b0, 3'd0, 1'b0, 1'b0);
    check(out_word === held && out_valid, "R10 word held", out_word, held);
    step(1'b1, 16'hCCCC, 16'hDDDD, 1'b0, 3'd0, 1'b0, 1'b1);
    idle(3'd0, 1'b0); idle(3'd0, 1'b0);

    // Random phase, all settings moving
    for (int c = 0; c < 6000; c++) begin
      step(($urandom % 4) != 0, 16'($urandom), 16'($urandom), ($urandom % 16) == 0,
           3'($urandom % 8), 1'($urandom % 2), ($urandom % 4) != 0);
    end
    step(1'b0, 16'h0, 16'h0, 1'b1, 3'd0, 1'b0, 1'b1);
    for (int c = 0; c < 6; c++) idle(3'd0, 1'b0);
    check(exp_q.size() == 0, "R10 every pair delivered once", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule